// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This block chooses which of seven interrupt sources is presented to a small 8-bit processor core. The sources are two external interrupt pins, two timers, a serial port and two buffer-full handshake flags of a parallel port. The serial port has separate receive and transmit flags, which are merged into one request. A configuration byte assigns each source to a high or a low level. An enable byte gates each source and also holds a global enable. Among eligible requests, the high level wins. Within a level, a fixed scan order decides.

The winner is presented as a request strobe with its vector address and level. Both stay frozen until the core acknowledges them. On acknowledge, the block marks that level as in service. This allows a high-level handler to nest over a low-level one and blocks every other kind of preemption. A return pulse from the core ends the innermost active service. The vector addresses do not follow the scan order for the two buffer flags and the serial port. Each vector address is computed as base plus stride times a per-source slot.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `irq_req`, `active_hi` and `active_lo` are 0 and `irq_vec` is 0.
- R2: Within one level, the winner is the first requesting source in this scan order: external 0, timer 0, external 1, timer 1, output-buffer-full, serial, input-buffer-full.
- R3: Each source has a fixed vector address: external 0 = 03h, timer 0 = 0Bh, external 1 = 13h, timer 1 = 1Bh, serial = 23h, input-buffer-full = 2Bh, output-buffer-full = 33h.
- R4: In `prio_cfg`, each bit selects one source's level: bit 0 external 0, bit 1 timer 0, bit 2 external 1, bit 3 timer 1, bit 4 serial, bit 5 input-buffer-full, bit 6 output-buffer-full. A value of 1 means high level. Bit 7 has no effect. An eligible high-level request is chosen before any low-level one, whatever the scan order; `irq_level` is 1 for high.
- R5: `en_cfg` uses the same bit layout for the per-source enables, and bit 7 is the global enable. A source is eligible only when its own enable bit and the global enable are both 1.
- R6: The serial source requests when either `ser_rx_flag` or `ser_tx_flag` is 1.
- R7: While `irq_req` is 1 and `irq_ack` is 0, `irq_req`, `irq_vec` and `irq_level` hold their values on the next cycle, even if the input flags change.
- R8: An `irq_ack` while `irq_req` is 1 clears `irq_req` and sets the in-service flag for the presented level. A high-level request is presented while a low-level service is active.
- R9: No request is presented while `active_hi` is 1.
- R10: A low-level request is not presented while `active_lo` is 1.
- R11: A `reti` pulse clears `active_hi` if it is set. Otherwise it clears `active_lo`.
- R12: A flag that is 1 at clock edge k, with no service blocking it, raises `irq_req` at edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext0_flag | input | 1 | External interrupt 0 request flag |
| tmr0_flag | input | 1 | Timer 0 overflow flag |
| ext1_flag | input | 1 | External interrupt 1 request flag |
| tmr1_flag | input | 1 | Timer 1 overflow flag |
| obuf_flag | input | 1 | Parallel-port output buffer full flag |
| ser_rx_flag | input | 1 | Serial receive flag |
| ser_tx_flag | input | 1 | Serial transmit flag |
| ibuf_flag | input | 1 | Parallel-port input buffer full flag |
| prio_cfg | input | CFG_W | Level select per source (1 = high) |
| en_cfg | input | CFG_W | Per-source enables plus global enable in the top bit |
| irq_req | output | 1 | Request strobe to the core |
| irq_vec | output | VEC_W | Vector address of the presented source |
| irq_level | output | 1 | Level of the presented source (1 = high) |
| irq_ack | input | 1 | Core accepts the presented request |
| reti | input | 1 | Return-from-interrupt pulse |
| active_hi | output | 1 | High-level service in progress |
| active_lo | output | 1 | Low-level service in progress |

## Verification
The assertions assume that the core raises `irq_ack` only while a request is presented. They also assume `reti` arrives only when a service is active and never in the same cycle as an acknowledge. The bench meets these assumptions. One process issues every acknowledge, and only in response to an observed strobe. The driver pulses `reti` only after that process reports the acknowledge complete. The driver also lowers each served source's flag before it returns, so the serviced source cannot re-request through its own stale flag.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

   // number of request sources, counted in scan order
   localparam int unsigned NSRC = 7;

   // scan-order index of each source
   typedef enum logic [2:0] {
      SRC_EXT0 = 3'd0,
      SRC_TMR0 = 3'd1,
      SRC_EXT1 = 3'd2,
      SRC_TMR1 = 3'd3,
      SRC_OBUF = 3'd4,
      SRC_SER  = 3'd5,
      SRC_IBUF = 3'd6
   } src_e;

   // slot of a scan-order index: selects both its configuration bit
   // and its vector position (base + stride * slot)
   function automatic int unsigned slot_of(input int unsigned idx);
      case (idx)
         32'd4:   return 32'd6;
         32'd5:   return 32'd4;
         32'd6:   return 32'd5;
         default: return idx;
      endcase
   endfunction

endpackage

// File: rtl/prio_irq_sampler.sv
module prio_irq_sampler #(
   parameter int unsigned NSRC       = 7,
   parameter bit          SAMPLE_REG = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] raw,
   output logic [NSRC-1:0] seen
);

   generate
      if (SAMPLE_REG) begin : g_reg
         logic [NSRC-1:0] held;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) held <= '0;
            else        held <= raw;
         end
         assign seen = held;
      end else begin : g_thru
         assign seen = raw;
      end
   endgenerate

endmodule

// File: rtl/prio_irq_pick.sv
module prio_irq_pick #(
   parameter int unsigned NSRC  = 7,
   parameter int unsigned IDX_W = $clog2(NSRC)
) (
   input  logic [NSRC-1:0]  req,
   output logic             hit,
   output logic [IDX_W-1:0] idx
);

   // lowest set index wins: scan from the top so the last write is the first hit
   always_comb begin
      hit = |req;
      idx = '0;
      for (int i = NSRC - 1; i >= 0; i--) begin
         if (req[i]) idx = IDX_W'(i);
      end
   end

endmodule

// File: rtl/prio_irq_service.sv
module prio_irq_service (
   input  logic clk,
   input  logic rst_n,
   input  logic grant,
   input  logic grant_hi,
   input  logic reti,
   output logic in_hi,
   output logic in_lo
);

   logic hi_n, lo_n;

   always_comb begin
      hi_n = in_hi;
      lo_n = in_lo;
      if (reti) begin
         if (in_hi) hi_n = 1'b0;
         else       lo_n = 1'b0;
      end
      if (grant) begin
         if (grant_hi) hi_n = 1'b1;
         else          lo_n = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_hi <= 1'b0;
         in_lo <= 1'b0;
      end else begin
         in_hi <= hi_n;
         in_lo <= lo_n;
      end
   end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
   import prio_irq_pkg::*;
#(
   parameter int unsigned VEC_W      = 8,
   parameter int unsigned VEC_BASE   = 3,
   parameter int unsigned VEC_STRIDE = 8,
   parameter int unsigned CFG_W      = 8,
   parameter bit          SAMPLE_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ext0_flag,
   input  logic             tmr0_flag,
   input  logic             ext1_flag,
   input  logic             tmr1_flag,
   input  logic             obuf_flag,
   input  logic             ser_rx_flag,
   input  logic             ser_tx_flag,
   input  logic             ibuf_flag,
   input  logic [CFG_W-1:0] prio_cfg,
   input  logic [CFG_W-1:0] en_cfg,
   output logic             irq_req,
   output logic [VEC_W-1:0] irq_vec,
   output logic             irq_level,
   input  logic             irq_ack,
   input  logic             reti,
   output logic             active_hi,
   output logic             active_lo
);

   localparam int unsigned IDX_W    = $clog2(NSRC);
   localparam int unsigned GLOB_BIT = CFG_W - 1;
   localparam int unsigned TOP_VEC  = VEC_BASE + VEC_STRIDE * (NSRC - 1);

   // elaboration checks
   generate
      if (CFG_W != NSRC + 1) begin : g_bad_cfg
         $error("CFG_W must equal the source count plus one");
      end
      if (TOP_VEC >= (1 << VEC_W)) begin : g_bad_vec
         $error("vector table does not fit in VEC_W bits");
      end
      if (VEC_STRIDE == 0) begin : g_bad_stride
         $error("VEC_STRIDE must be nonzero");
      end
   endgenerate

   // raw requests in scan order; serial merges its two flags
   logic [NSRC-1:0] raw_req;
   assign raw_req[SRC_EXT0] = ext0_flag;
   assign raw_req[SRC_TMR0] = tmr0_flag;
   assign raw_req[SRC_EXT1] = ext1_flag;
   assign raw_req[SRC_TMR1] = tmr1_flag;
   assign raw_req[SRC_OBUF] = obuf_flag;
   assign raw_req[SRC_SER]  = ser_rx_flag | ser_tx_flag;
   assign raw_req[SRC_IBUF] = ibuf_flag;

   logic [NSRC-1:0] seen_req;

   prio_irq_sampler #(.NSRC(NSRC), .SAMPLE_REG(SAMPLE_REG)) u_sampler (
      .clk   (clk),
      .rst_n (rst_n),
      .raw   (raw_req),
      .seen  (seen_req)
   );

   // configuration bits re-ordered into scan order
   logic [NSRC-1:0] lvl_scan, en_scan;
   generate
      for (genvar g = 0; g < NSRC; g++) begin : g_map
         assign lvl_scan[g] = prio_cfg[slot_of(g)];
         assign en_scan[g]  = en_cfg[slot_of(g)];
      end
   endgenerate

   logic unused_prio_top;
   assign unused_prio_top = prio_cfg[GLOB_BIT];

   logic [NSRC-1:0] eligible, hi_set, lo_set;
   assign eligible = seen_req & en_scan & {NSRC{en_cfg[GLOB_BIT]}};
   assign hi_set   = eligible & lvl_scan;
   assign lo_set   = eligible & ~lvl_scan;

   logic             hi_hit, lo_hit;
   logic [IDX_W-1:0] hi_idx, lo_idx;

   prio_irq_pick #(.NSRC(NSRC), .IDX_W(IDX_W)) u_pick_hi (
      .req (hi_set),
      .hit (hi_hit),
      .idx (hi_idx)
   );

   prio_irq_pick #(.NSRC(NSRC), .IDX_W(IDX_W)) u_pick_lo (
      .req (lo_set),
      .hit (lo_hit),
      .idx (lo_idx)
   );

   // level gating against the services in progress
   logic             take_hi, take_lo, take_any;
   logic [IDX_W-1:0] win_idx;
   logic [VEC_W-1:0] win_vec;

   assign take_hi  = hi_hit && !active_hi;
   assign take_lo  = lo_hit && !active_hi && !active_lo && !take_hi;
   assign take_any = take_hi || take_lo;
   assign win_idx  = take_hi ? hi_idx : lo_idx;

   always_comb begin
      win_vec = VEC_W'(VEC_BASE + VEC_STRIDE * slot_of(32'(win_idx)));
   end

   // presented request: frozen until acknowledged
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_req   <= 1'b0;
         irq_vec   <= '0;
         irq_level <= 1'b0;
      end else if (!irq_req) begin
         if (take_any) begin
            irq_req   <= 1'b1;
            irq_vec   <= win_vec;
            irq_level <= take_hi;
         end
      end else if (irq_ack) begin
         irq_req <= 1'b0;
      end
   end

   prio_irq_service u_service (
      .clk      (clk),
      .rst_n    (rst_n),
      .grant    (irq_req && irq_ack),
      .grant_hi (irq_level),
      .reti     (reti),
      .in_hi    (active_hi),
      .in_lo    (active_lo)
   );

endmodule

// File: rtl/prio_irq_chk.sv
module prio_irq_chk #(
   parameter int unsigned VEC_W      = 8,
   parameter int unsigned VEC_BASE   = 3,
   parameter int unsigned VEC_STRIDE = 8,
   parameter int unsigned NSLOT      = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             irq_req,
   input logic [VEC_W-1:0] irq_vec,
   input logic             irq_level,
   input logic             irq_ack,
   input logic             reti,
   input logic             active_hi,
   input logic             active_lo
);

   localparam int unsigned TOP_VEC = VEC_BASE + VEC_STRIDE * (NSLOT - 1);

   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req && !irq_ack |=> irq_req && $stable(irq_vec) && $stable(irq_level));

   assert_vec_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (32'(irq_vec) >= VEC_BASE) && (32'(irq_vec) <= TOP_VEC)
                  && ((32'(irq_vec) - VEC_BASE) % VEC_STRIDE == 0));

   assert_ack_hi_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req && irq_ack && irq_level |=> active_hi && !irq_req);

   assert_ack_lo_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req && irq_ack && !irq_level |=> active_lo && !irq_req);

   assert_no_over_hi_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_req) |-> !$past(active_hi));

   assert_no_lo_on_lo_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_req) && !irq_level |-> !$past(active_lo));

   assert_reti_hi_R11: assert property (@(posedge clk) disable iff (!rst_n)
      reti && active_hi && !(irq_req && irq_ack) |=> !active_hi);

   assert_reti_lo_R11: assert property (@(posedge clk) disable iff (!rst_n)
      reti && !active_hi && active_lo && !(irq_req && irq_ack) |=> !active_lo);

   assert_reti_keeps_lo_R11: assert property (@(posedge clk) disable iff (!rst_n)
      reti && active_hi && active_lo |=> active_lo);

endmodule

bind prio_irq_ctrl prio_irq_chk #(
   .VEC_W      (VEC_W),
   .VEC_BASE   (VEC_BASE),
   .VEC_STRIDE (VEC_STRIDE),
   .NSLOT      (prio_irq_pkg::NSRC)
) u_prio_irq_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .irq_req   (irq_req),
   .irq_vec   (irq_vec),
   .irq_level (irq_level),
   .irq_ack   (irq_ack),
   .reti      (reti),
   .active_hi (active_hi),
   .active_lo (active_lo)
);

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ext0_flag = 0, tmr0_flag = 0, ext1_flag = 0, tmr1_flag = 0;
   logic       obuf_flag = 0, ser_rx_flag = 0, ser_tx_flag = 0, ibuf_flag = 0;
   logic [7:0] prio_cfg = '0;
   logic [7:0] en_cfg = '0;
   logic       irq_ack = 1'b0;
   logic       reti = 1'b0;
   logic       irq_req, irq_level, active_hi, active_lo;
   logic [7:0] irq_vec;

   always #(CLK_PERIOD / 2) clk = ~clk;

   prio_irq_ctrl i_prio_irq_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .ext0_flag   (ext0_flag),
      .tmr0_flag   (tmr0_flag),
      .ext1_flag   (ext1_flag),
      .tmr1_flag   (tmr1_flag),
      .obuf_flag   (obuf_flag),
      .ser_rx_flag (ser_rx_flag),
      .ser_tx_flag (ser_tx_flag),
      .ibuf_flag   (ibuf_flag),
      .prio_cfg    (prio_cfg),
      .en_cfg      (en_cfg),
      .irq_req     (irq_req),
      .irq_vec     (irq_vec),
      .irq_level   (irq_level),
      .irq_ack     (irq_ack),
      .reti        (reti),
      .active_hi   (active_hi),
      .active_lo   (active_lo)
   );

   typedef struct {
      int    vec;
      int    lvl;
      string tag;
   } exp_t;

   exp_t exp_q[$];
   int   n_cmp = 0;
   int   n_bad = 0;
   int   served = 0;
   int   hold_cycles = 0;
   bit   done = 0;

   task automatic chk(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic push_exp(input int vec, input int lvl, input string tag);
      exp_t e;
      e.vec = vec;
      e.lvl = lvl;
      e.tag = tag;
      exp_q.push_back(e);
   endtask

   task automatic wait_served(input int target);
      wait (served >= target);
   endtask

   task automatic expect_irq(input int vec, input int lvl, input string tag);
      int t;
      t = served + 1;
      push_exp(vec, lvl, tag);
      wait_served(t);
   endtask

   task automatic pulse_reti();
      @(negedge clk) reti = 1'b1;
      @(negedge clk) reti = 1'b0;
   endtask

   task automatic clear_src(input int i);
      case (i)
         0: ext0_flag = 1'b0;
         1: tmr0_flag = 1'b0;
         2: ext1_flag = 1'b0;
         3: tmr1_flag = 1'b0;
         4: obuf_flag = 1'b0;
         5: begin ser_rx_flag = 1'b0; ser_tx_flag = 1'b0; end
         default: ibuf_flag = 1'b0;
      endcase
   endtask

   // monitor: pops the scoreboard on each new strobe and acknowledges it
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && irq_req && !irq_ack) begin
            if (exp_q.size() == 0) begin
               chk("R2 unexpected request vec", int'(irq_vec), 0);
               irq_ack = 1'b1;
               @(negedge clk) irq_ack = 1'b0;
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               chk({e.tag, " vec"}, int'(irq_vec), e.vec);
               chk({e.tag, " level"}, int'(irq_level), e.lvl);
               for (int k = 0; k < hold_cycles; k++) begin
                  @(negedge clk);
                  chk("R7 strobe held", int'(irq_req), 1);
                  chk("R7 vec held", int'(irq_vec), e.vec);
               end
               irq_ack = 1'b1;
               @(negedge clk) irq_ack = 1'b0;
               served++;
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      int vtab[7];
      int t;
      vtab = '{'h03, 'h0B, 'h13, 'h1B, 'h33, 'h23, 'h2B};

      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      // R1: reset state
      chk("R1 irq_req", int'(irq_req), 0);
      chk("R1 irq_vec", int'(irq_vec), 0);
      chk("R1 active_hi", int'(active_hi), 0);
      chk("R1 active_lo", int'(active_lo), 0);

      // R5: global enable off blocks everything
      en_cfg = 8'h7F;
      ext0_flag = 1'b1;
      cyc(4);
      chk("R5 global off", int'(irq_req), 0);
      // R5: ext0 disabled individually, timer 0 wins
      en_cfg = 8'hFE;
      tmr0_flag = 1'b1;
      expect_irq('h0B, 0, "R5 per-source enable");
      tmr0_flag = 1'b0;
      ext0_flag = 1'b0;
      pulse_reti();
      chk("R11 reti clears low", int'(active_lo), 0);

      // R12: latency from flag to strobe
      en_cfg = 8'hFF;
      prio_cfg = 8'h00;
      t = served + 1;
      push_exp('h13, 0, "R12 ext1");
      ext1_flag = 1'b1;
      cyc(1);
      chk("R12 not yet", int'(irq_req), 0);
      cyc(1);
      chk("R12 strobe", int'(irq_req), 1);
      wait_served(t);
      ext1_flag = 1'b0;
      pulse_reti();

      // R2 / R3: all sources at low level, bit 7 of prio_cfg set (R4: no effect)
      prio_cfg = 8'h80;
      ext0_flag = 1; tmr0_flag = 1; ext1_flag = 1; tmr1_flag = 1;
      obuf_flag = 1; ser_rx_flag = 1; ibuf_flag = 1;
      for (int i = 0; i < 7; i++) begin
         expect_irq(vtab[i], 0, "R2 R3 R4 scan order");
         clear_src(i);
         pulse_reti();
      end
      chk("R11 all low services ended", int'(active_lo), 0);

      // R6: transmit flag alone raises the serial request
      prio_cfg = 8'h00;
      ser_tx_flag = 1'b1;
      expect_irq('h23, 0, "R6 serial tx");
      clear_src(5);
      pulse_reti();

      // R4: high level wins against earlier scan position
      prio_cfg = 8'h40;
      ext0_flag = 1'b1;
      obuf_flag = 1'b1;
      expect_irq('h33, 1, "R4 obuf high");
      chk("R8 active_hi after high ack", int'(active_hi), 1);
      obuf_flag = 1'b0;
      prio_cfg = 8'h42;
      tmr0_flag = 1'b1;
      cyc(5);
      chk("R9 nothing over high", int'(irq_req), 0);
      pulse_reti();
      expect_irq('h0B, 1, "R4 tmr0 high before ext0 low");
      tmr0_flag = 1'b0;
      pulse_reti();
      expect_irq('h03, 0, "R4 ext0 low");
      ext0_flag = 1'b0;

      // R8: high preempts an active low service
      prio_cfg = 8'h20;
      ibuf_flag = 1'b1;
      expect_irq('h2B, 1, "R8 preempt low");
      chk("R8 active_hi", int'(active_hi), 1);
      chk("R8 active_lo kept", int'(active_lo), 1);
      ibuf_flag = 1'b0;
      tmr1_flag = 1'b1;
      pulse_reti();
      chk("R11 reti ends high first", int'(active_hi), 0);
      chk("R11 low still active", int'(active_lo), 1);
      cyc(5);
      chk("R10 no low over low", int'(irq_req), 0);
      pulse_reti();
      expect_irq('h1B, 0, "R10 tmr1 after low ends");
      tmr1_flag = 1'b0;
      pulse_reti();
      chk("R11 low cleared", int'(active_lo), 0);

      // R7: strobe held while flags change
      prio_cfg = 8'h00;
      hold_cycles = 4;
      t = served + 1;
      push_exp('h13, 0, "R7 ext1 held");
      ext1_flag = 1'b1;
      cyc(3);
      ext1_flag = 1'b0;
      ext0_flag = 1'b1;
      wait_served(t);
      hold_cycles = 0;
      pulse_reti();
      expect_irq('h03, 0, "R7 ext0 after hold");
      ext0_flag = 1'b0;
      pulse_reti();
      cyc(4);
      chk("R1 idle at end", int'(irq_req), 0);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule